// File: doc/BRIEF.md
# Masked pin-change interrupt detector

This block watches a bank of general-purpose pins split into groups of eight (two groups by default, sixteen pins) and raises one sticky flag per group whenever any pin whose mask bit is set changes level, in either direction. The change is detected whether the pin is driven from outside or driven by the chip itself, so software can provoke its own interrupt by writing to an output pin.

Each pin passes through a transparent latch that is open while the clock is low. A synchronising flop follows it, then a compare stage that checks the newly sampled level against the level sampled one cycle earlier. The masked difference becomes a registered set pulse, and that pulse sets the group flag one cycle later. Each group's interrupt request is its flag gated by a per-group enable. A write-one-to-clear strobe per group clears the flag. A separate wake output is purely combinational: it compares the live pins with the last sampled levels, so it works while the clock is stopped.

Top module: `pcd_top`

## Requirements
- R1: A rising or a falling level change on a pin whose mask bit is 1 sets that pin's group flag. When the pin changes while the clock is low, before rising edge E1, the flag reads 0 after edge E2 and 1 after edge E3.
- R2: A pin whose mask bit is 0 never sets its group flag, whether the pin toggles or its mask bit is changed while the pin holds a level.
- R3: Pins 8g to 8g+7 (with pin_i bit 0 as pin 0) feed only group g. A change in one group leaves the other group's flag at 0.
- R4: A group flag stays at 1 until its bit of flag_clr_i is 1 at a rising edge. It reads 0 after that edge. A clear strobe on a flag that is already 0 leaves it at 0.
- R5: When a set pulse and a clear strobe for the same group meet at one rising edge, the flag stays 1.
- R6: irq_o[g] is flag_o[g] AND grp_en_i[g]. grp_en_i has no effect on flag_o.
- R7: wake_o is 1, with no clock edge needed, while any pin whose mask bit is 1 differs from its last sampled level. It returns to 0 at the first rising edge that samples the new level. Changes on pins whose mask bit is 0 never raise it.
- R8: A synchronous active-high reset clears flag_o and irq_o. Pin levels that are held during reset cause no flag after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pin latches are open while it is low |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Live pin levels, bit 8g+k is pin k of group g |
| mask_i | input | 16 | Per-pin contribute mask, byte g belongs to group g |
| grp_en_i | input | 2 | Per-group interrupt enable |
| flag_clr_i | input | 2 | Per-group write-one-to-clear strobe |
| flag_o | output | 2 | Sticky per-group change flags |
| irq_o | output | 2 | Per-group interrupt request |
| wake_o | output | 1 | Asynchronous change indication for wake-up |

## Verification
The bench checks the exact three-edge latency for both rising and falling changes. A design that skipped the set-pulse stage, or the synchroniser, would raise the flag one edge early. It toggles masked-out pins and also turns a mask bit on while its pin holds a high level. A design that compares masked samples instead of masking the difference would set a flag on the mask write. It lines up a clear strobe with a fresh set pulse, which a clear-priority design would lose. It also stops the clock and toggles a pin, so a wake output that depended on a clock edge would stay low.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  parameter int unsigned GROUPS         = 2;
  parameter int unsigned PINS_PER_GROUP = 8;
endpackage

// File: rtl/pcd_pin_sampler.sv
module pcd_pin_sampler #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] samp_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] prev_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // transparent while the clock is low, holds across the high phase
    always_latch begin
      if (!clk) lat_q[i] = pin_i[i];
    end

    always_ff @(posedge clk) begin
      sync_q[i] <= lat_q[i];
      prev_q[i] <= sync_q[i];
    end
  end

  assign samp_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pcd_group_flag.sv
module pcd_group_flag #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] samp_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [WIDTH-1:0] chg;
  logic             set_q;
  logic             flag_q;

  // the mask gates the difference, so a mask write alone never fires
  assign chg = (samp_i ^ prev_i) & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      set_q  <= |chg;
      flag_q <= set_q | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;

  // R1 / R2: a flag rises only two edges after a masked difference
  a_r1_rise_from_change: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(|((samp_i ^ prev_i) & mask_i), 2));

  // R4: flag holds without a clear
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);

  // R4: clear without a competing set empties the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_q) |=> !flag_q);

  // R5: a set pulse always lands, clear or not
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_q |=> flag_q);
endmodule

// File: rtl/pcd_wake_detect.sv
module pcd_wake_detect #(
  parameter int unsigned NPINS = 16
) (
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] samp_i,
  input  logic [NPINS-1:0] mask_i,
  output logic             wake_o
);
  assign wake_o = |((pin_i ^ samp_i) & mask_i);
endmodule

// File: rtl/pcd_top.sv
module pcd_top #(
  parameter int unsigned GROUPS         = pcd_pkg::GROUPS,
  parameter int unsigned PINS_PER_GROUP = pcd_pkg::PINS_PER_GROUP
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [GROUPS*PINS_PER_GROUP-1:0]   pin_i,
  input  logic [GROUPS*PINS_PER_GROUP-1:0]   mask_i,
  input  logic [GROUPS-1:0]                  grp_en_i,
  input  logic [GROUPS-1:0]                  flag_clr_i,
  output logic [GROUPS-1:0]                  flag_o,
  output logic [GROUPS-1:0]                  irq_o,
  output logic                               wake_o
);
  localparam int unsigned NPINS = GROUPS * PINS_PER_GROUP;

  logic [NPINS-1:0]  samp;
  logic [NPINS-1:0]  prev;
  logic [GROUPS-1:0] flag;

  pcd_pin_sampler #(.NPINS(NPINS)) u_sampler (
    .clk    (clk),
    .pin_i  (pin_i),
    .samp_o (samp),
    .prev_o (prev)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pcd_group_flag #(.WIDTH(PINS_PER_GROUP)) u_flag (
      .clk    (clk),
      .rst    (rst),
      .samp_i (samp[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .prev_i (prev[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .mask_i (mask_i[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .clr_i  (flag_clr_i[g]),
      .flag_o (flag[g])
    );
  end

  assign flag_o = flag;
  assign irq_o  = flag & grp_en_i;

  pcd_wake_detect #(.NPINS(NPINS)) u_wake (
    .pin_i  (pin_i),
    .samp_i (samp),
    .mask_i (mask_i),
    .wake_o (wake_o)
  );

  // R7: pins unchanged across an edge leave nothing pending for wake-up
  a_r7_wake_settles: assert property (@(posedge clk) disable iff (rst)
    $stable(pin_i) |-> !wake_o);
endmodule

// File: tb/pcd_top_tb.sv
module pcd_top_tb;
  logic        clk = 1'b0;
  logic        run = 1'b1;
  logic        rst = 1'b1;
  logic [15:0] pin_i = 16'h0000;
  logic [15:0] mask_i = 16'hFFFF;
  logic [1:0]  grp_en_i = 2'b11;
  logic [1:0]  flag_clr_i = 2'b00;
  logic [1:0]  flag_o;
  logic [1:0]  irq_o;
  logic        wake_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pcd_top u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .mask_i(mask_i),
    .grp_en_i(grp_en_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  always begin
    #10;
    if (run) clk = ~clk;
  end

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr_i = 2'b11;
    edges(1);
    flag_clr_i = 2'b00;
  endtask

  task automatic t_reset();
    pin_i = 16'h00F0;
    rst = 1'b1;
    edges(4);
    rst = 1'b0;
    chk(flag_o, 2'b00, "R8 flags in reset");
    chk(irq_o, 2'b00, "R8 irq in reset");
    edges(4);
    chk(flag_o, 2'b00, "R8 no flag from held pins");
    chk({1'b0, wake_o}, 2'b00, "R8 no wake from held pins");
  endtask

  task automatic t_rise_latency();
    pin_i[3] = 1'b1;
    edges(2);
    chk(flag_o, 2'b00, "R1 rise flag not yet after E2");
    edges(1);
    chk(flag_o, 2'b01, "R1 rise flag after E3 / R3 group 1 idle");
    chk(irq_o, 2'b01, "R6 irq follows flag");
    clear_all();
  endtask

  task automatic t_fall_and_groups();
    pin_i[4] = 1'b0;
    edges(3);
    chk(flag_o, 2'b01, "R1 falling change sets group 0");
    clear_all();
    pin_i[9] = 1'b1;
    edges(3);
    chk(flag_o, 2'b10, "R3 pin 9 sets only group 1");
    clear_all();
  endtask

  task automatic t_mask();
    mask_i = 16'hFF0F;
    pin_i[5] = ~pin_i[5];
    #1;
    chk({1'b0, wake_o}, 2'b00, "R7 masked pin no wake");
    edges(5);
    chk(flag_o, 2'b00, "R2 masked toggle ignored");
    pin_i[5] = 1'b1;
    edges(3);
    mask_i = 16'hFFFF;
    edges(5);
    chk(flag_o, 2'b00, "R2 mask write on high pin ignored");
    mask_i = 16'h00FF;
    pin_i[14] = ~pin_i[14];
    edges(5);
    chk(flag_o, 2'b00, "R2 masked group 1 toggle ignored");
    mask_i = 16'hFFFF;
    clear_all();
  endtask

  task automatic t_sticky_clear();
    pin_i[0] = ~pin_i[0];
    edges(3);
    edges(10);
    chk(flag_o, 2'b01, "R4 flag sticky");
    flag_clr_i = 2'b01;
    edges(1);
    flag_clr_i = 2'b00;
    chk(flag_o, 2'b00, "R4 clear strobe");
    flag_clr_i = 2'b10;
    edges(1);
    flag_clr_i = 2'b00;
    chk(flag_o, 2'b00, "R4 clear on empty flag");
  endtask

  task automatic t_collision();
    pin_i[1] = ~pin_i[1];
    edges(3);
    pin_i[1] = ~pin_i[1];
    edges(2);
    flag_clr_i = 2'b01;
    edges(1);
    flag_clr_i = 2'b00;
    chk(flag_o, 2'b01, "R5 set wins over clear");
    clear_all();
    chk(flag_o, 2'b00, "R5 later clear works");
  endtask

  task automatic t_enable();
    grp_en_i = 2'b00;
    pin_i[15] = ~pin_i[15];
    edges(3);
    chk(flag_o, 2'b10, "R6 flag independent of enable");
    chk(irq_o, 2'b00, "R6 irq gated off");
    grp_en_i = 2'b10;
    #1;
    chk(irq_o, 2'b10, "R6 irq on enable");
    grp_en_i = 2'b11;
    clear_all();
  endtask

  task automatic t_wake();
    pin_i[6] = ~pin_i[6];
    #1;
    chk({1'b0, wake_o}, 2'b01, "R7 wake immediate");
    @(posedge clk);
    #1;
    chk({1'b0, wake_o}, 2'b00, "R7 wake drops after sample");
    edges(3);
    clear_all();
    run = 1'b0;
    #5;
    pin_i[10] = ~pin_i[10];
    #100;
    chk({1'b0, wake_o}, 2'b01, "R7 wake with clock stopped");
    chk(flag_o, 2'b00, "R7 no flag while stopped");
    run = 1'b1;
    edges(4);
    chk(flag_o, 2'b10, "R1 flag after clock restart");
    chk({1'b0, wake_o}, 2'b00, "R7 wake cleared after restart");
    clear_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_rise_latency();
    t_fall_and_groups();
    t_mask();
    t_sticky_clear();
    t_collision();
    t_enable();
    t_wake();
    finish_run();
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule